// File: doc/BRIEF.md
# Dual-Slope PWM Compare Unit

This block holds a 16-bit counter that climbs from zero to an upper limit and then falls back to zero, advancing once per cycle in which the prescaled count enable is high. Two compare channels, A and B, watch the counter and drive one waveform pin each. Because each pin is set on one slope and cleared on the other, the pulses stay centred in the period, which suits motor and power stages that need symmetric PWM.

A 4-bit waveform mode selects the dual-slope behaviour. It chooses between an upper limit taken from a dedicated limit input and one taken from channel A's compare value. It also chooses whether new compare values take effect at the top or at the bottom of the ramp. Each channel has a 2-bit output mode that sets how its pin reacts to a match. The options are: not driven, toggle (channel A only), non-inverting, or inverting. Compare values are double-buffered, so a value changed in mid-period never produces a glitch. Each channel also raises a one-cycle match flag.

Top module: `dualslope_pwm`

## Requirements
- R1: While `rst` is high, at the next clock edge both pins, both output enables and both flags go low, the counter goes to zero and the count direction goes to up.
- R2: In waveform modes 8 to 11, each cycle with `cnt_en` high moves the counter one step along 0,1,…,TOP,TOP-1,…,1,0,1,… so a period is 2×TOP steps. A cycle with `cnt_en` low leaves the counter and the pins unchanged.
- R3: In modes 9 and 11, TOP is channel A's active compare value. In modes 8 and 10, TOP is the active copy of `top_val`.
- R4: In any mode other than 8 to 11, the counter stays at zero and the flags stay low. Both output enables are low. The active compare and limit copies follow their inputs on every cycle.
- R5: Output mode 00 leaves a channel's output enable low and its pin level unchanged.
- R6: Output mode 01 makes pin A toggle on every match in modes 9 and 11, with its output enable high. Channel B has its output enable low under 01 in every mode, and so does channel A in modes 8 and 10.
- R7: Output mode 10 clears the pin on a match while counting up and sets it on a match while counting down. A match at zero counts as up and a match at TOP counts as down.
- R8: Output mode 11 sets the pin on an up-count match and clears it on a down-count match, with the same endpoint directions as R7.
- R9: With output mode 1x and an active compare value equal to TOP, the match at TOP changes nothing. Instead, the step at zero sets the pin for mode 10 and clears it for mode 11.
- R10: The active compare and limit copies reload from the inputs on the step at which the counter is at TOP going up, in modes 10 and 11, or on the step at zero, in modes 8 and 9. A compare made on that same step uses the old values.
- R11: A flag is high for exactly one cycle after each step in which the counter equals that channel's active compare value, including a match at TOP whose pin action is dropped. It is never high after a cycle without a step.
- R12: Pins, output enables and flags are registered and change in the cycle after the step or mode change that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Prescaled count step enable |
| wave_mode | input | 4 | Waveform mode; 8 to 11 are dual-slope |
| om_a | input | 2 | Channel A output mode |
| om_b | input | 2 | Channel B output mode |
| cmp_a | input | CNT_W | Pending compare value, channel A |
| cmp_b | input | CNT_W | Pending compare value, channel B |
| top_val | input | CNT_W | Pending upper limit for modes 8 and 10 |
| pwm_a | output | 1 | Channel A waveform level |
| pwm_a_oe | output | 1 | Channel A drives its pin |
| pwm_b | output | 1 | Channel B waveform level |
| pwm_b_oe | output | 1 | Channel B drives its pin |
| hit_a | output | 1 | Channel A match pulse |
| hit_b | output | 1 | Channel B match pulse |

## Verification
The counter and channel properties take for granted that TOP stays at least 1 while a dual-slope mode runs. They also assume the limit does not shrink below the counter while the counter is still rising. The stimulus meets both conditions: it fixes TOP for each run and starts every run from reset. It then spends two idle cycles so that the active copies hold the chosen values before a dual-slope mode is selected. Compare values are changed only in the double-buffering runs, and only on a falling edge, so the reload step sees a settled value.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef struct packed {
    logic dual;   // counter runs as an up/down ramp
    logic pc;     // reload at TOP (1) or at zero (0)
    logic top_a;  // limit comes from channel A
  } wmode_t;

  function automatic wmode_t decode_mode(input logic [3:0] wm);
    wmode_t m;
    m.dual  = (wm[3:2] == 2'b10);
    m.pc    = wm[1];
    m.top_a = wm[0];
    return m;
  endfunction

endpackage

// File: rtl/dsp_counter.sv
module dsp_counter
  import dsp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  wmode_t       md,
  input  logic [W-1:0] cmp_a_in,
  input  logic [W-1:0] cmp_b_in,
  input  logic [W-1:0] top_in,
  output logic [W-1:0] cnt,
  output logic [W-1:0] top_act,
  output logic [W-1:0] act_a,
  output logic [W-1:0] act_b,
  output logic         match_up
);

  localparam logic [W-1:0] ONE = W'(1);

  logic         dir_up;
  logic [W-1:0] top_reg;
  logic         load;

  assign top_act = md.top_a ? act_a : top_reg;

  // reload point for the double-buffered values
  assign load = !md.dual ||
                (step && (md.pc ? (dir_up && cnt >= top_act) : (cnt == '0)));

  // zero counts as rising, TOP as falling
  assign match_up = dir_up ? (cnt < top_act) : (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a   <= '0;
      act_b   <= '0;
      top_reg <= '0;
    end else if (load) begin
      act_a   <= cmp_a_in;
      act_b   <= cmp_b_in;
      top_reg <= top_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !md.dual) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (step) begin
      if (dir_up) begin
        if (cnt >= top_act) begin
          if (cnt != '0) begin
            cnt    <= cnt - ONE;
            dir_up <= 1'b0;
          end
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          cnt    <= (top_act == '0) ? '0 : ONE;
          dir_up <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  assert_up_step_R2: assert property (@(posedge clk) disable iff (rst)
    (md.dual && step && dir_up && cnt < top_act) |=> (cnt == $past(cnt) + ONE));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (md.dual && !step) |=> $stable(cnt));

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!md.dual) |=> (cnt == '0));

  assert_buf_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (md.dual && step && !md.pc && cnt != '0) |=> $stable(act_b));

endmodule

// File: rtl/dsp_channel.sv
module dsp_channel #(
  parameter int W    = 16,
  parameter bit IS_A = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         dual,
  input  logic         top_a,
  input  logic [1:0]   om,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] top_act,
  input  logic [W-1:0] act_cmp,
  input  logic         match_up,
  output logic         pin,
  output logic         oe,
  output logic         flag
);

  logic hit;
  logic at_top_eq;
  logic tgl_en;

  assign hit       = dual && step && (cnt == act_cmp);
  assign at_top_eq = (act_cmp == top_act);

  generate
    if (IS_A) begin : g_toggle
      assign tgl_en = top_a && (om == 2'b01);
    end else begin : g_no_toggle
      assign tgl_en = 1'b0;
      logic unused_top_a;
      assign unused_top_a = top_a;

      assert_b_no_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (!om[1]) |=> $stable(pin));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pin  <= 1'b0;
      oe   <= 1'b0;
      flag <= 1'b0;
    end else begin
      flag <= hit;
      oe   <= dual && (om[1] || tgl_en);
      if (dual && step) begin
        if (om[1]) begin
          if (at_top_eq) begin
            if (cnt == '0) pin <= ~om[0];
          end else if (hit) begin
            pin <= match_up ? om[0] : ~om[0];
          end
        end else if (tgl_en && hit) begin
          pin <= ~pin;
        end
      end
    end
  end

  assert_top_suppress_R9: assert property (@(posedge clk) disable iff (rst)
    (dual && step && om[1] && at_top_eq && cnt == top_act && cnt != '0) |=> $stable(pin));

  assert_flag_gap_R11: assert property (@(posedge clk) disable iff (rst)
    (!step) |=> !flag);

  assert_off_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (om == 2'b00) |=> $stable(pin));

  assert_clear_up_R7: assert property (@(posedge clk) disable iff (rst)
    (dual && step && om == 2'b10 && hit && match_up && !at_top_eq) |=> !pin);

endmodule

// File: rtl/dualslope_pwm.sv
module dualslope_pwm
  import dsp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [3:0]       wave_mode,
  input  logic [1:0]       om_a,
  input  logic [1:0]       om_b,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] top_val,
  output logic             pwm_a,
  output logic             pwm_a_oe,
  output logic             pwm_b,
  output logic             pwm_b_oe,
  output logic             hit_a,
  output logic             hit_b
);

  localparam int NCH = 2;

  wmode_t           md;
  logic [CNT_W-1:0] cnt, top_act, act_a, act_b;
  logic             match_up;

  logic [1:0]       om_arr  [NCH];
  logic [CNT_W-1:0] cmp_arr [NCH];
  logic [NCH-1:0]   pin_v, oe_v, flag_v;

  assign md = decode_mode(wave_mode);

  dsp_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (cnt_en),
    .md       (md),
    .cmp_a_in (cmp_a),
    .cmp_b_in (cmp_b),
    .top_in   (top_val),
    .cnt      (cnt),
    .top_act  (top_act),
    .act_a    (act_a),
    .act_b    (act_b),
    .match_up (match_up)
  );

  assign om_arr[0]  = om_a;
  assign om_arr[1]  = om_b;
  assign cmp_arr[0] = act_a;
  assign cmp_arr[1] = act_b;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dsp_channel #(.W(CNT_W), .IS_A(i == 0)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .step     (cnt_en),
        .dual     (md.dual),
        .top_a    (md.top_a),
        .om       (om_arr[i]),
        .cnt      (cnt),
        .top_act  (top_act),
        .act_cmp  (cmp_arr[i]),
        .match_up (match_up),
        .pin      (pin_v[i]),
        .oe       (oe_v[i]),
        .flag     (flag_v[i])
      );
    end
  endgenerate

  assign pwm_a    = pin_v[0];
  assign pwm_b    = pin_v[1];
  assign pwm_a_oe = oe_v[0];
  assign pwm_b_oe = oe_v[1];
  assign hit_a    = flag_v[0];
  assign hit_b    = flag_v[1];

  assert_b_oe_src_R6: assert property (@(posedge clk) disable iff (rst)
    pwm_b_oe |-> $past(om_b[1] && wave_mode[3:2] == 2'b10));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (wave_mode[3:2] != 2'b10) |=> (!hit_a && !hit_b && !pwm_a_oe && !pwm_b_oe));

endmodule

// File: tb/dualslope_pwm_tb.sv
`timescale 1ns/1ps
module dualslope_pwm_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic [3:0]   wave_mode = 4'd0;
  logic [1:0]   om_a = 2'b00, om_b = 2'b00;
  logic [W-1:0] cmp_a = '0, cmp_b = '0, top_val = '0;
  logic         pwm_a, pwm_a_oe, pwm_b, pwm_b_oe, hit_a, hit_b;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dualslope_pwm #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wave_mode(wave_mode),
    .om_a(om_a), .om_b(om_b), .cmp_a(cmp_a), .cmp_b(cmp_b), .top_val(top_val),
    .pwm_a(pwm_a), .pwm_a_oe(pwm_a_oe), .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe),
    .hit_a(hit_a), .hit_b(hit_b)
  );

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  function automatic logic pin_next(logic cur, logic [1:0] om, bit is_a, bit topa,
                                    int v, bit down, int c, int t);
    if (om[1]) begin
      if (c == t) return (v == 0) ? ~om[0] : cur;   // R9
      if (v == c) return down ? ~om[0] : om[0];     // R7, R8
      return cur;
    end
    if (is_a && topa && om == 2'b01 && v == c) return ~cur;  // R6
    return cur;
  endfunction

  function automatic string pin_tag(logic [1:0] om, int c, int t);
    if (om == 2'b00) return "R5";
    if (om == 2'b01) return "R6";
    if (c == t) return "R9";
    if (om == 2'b10) return "R7";
    return "R8";
  endfunction

  task automatic run_cfg(input logic [3:0] md, input logic [1:0] oa, input logic [1:0] ob,
                         input int ca, input int cb, input int tp, input int n,
                         input bit gate, input int chg_at, input int chg_val,
                         input string tag_ovr);
    bit dual, pc, topa, ea, eb, fa, fb;
    logic pa, pb;
    int aa, ab, t, k, p, v;
    bit down;
    string ta, tb_, toa, tob;
    @(negedge clk);
    rst = 1'b1; cnt_en = 1'b0; wave_mode = 4'd0;
    om_a = oa; om_b = ob; cmp_a = W'(ca); cmp_b = W'(cb); top_val = W'(tp);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);   // idle cycles load the active copies (R4)
    wave_mode = md;
    dual = (md[3:2] == 2'b10); pc = md[1]; topa = md[0];
    aa = ca; ab = cb; t = topa ? ca : tp;
    pa = 1'b0; pb = 1'b0; k = 0;
    ea = dual && (oa[1] || (oa == 2'b01 && topa));
    eb = dual && ob[1];
    toa = !dual ? "R4" : (oa == 2'b00 ? "R5" : "R6");
    tob = !dual ? "R4" : (ob == 2'b00 ? "R5" : "R6");
    for (int i = 0; i < n; i++) begin
      cnt_en = gate ? (i % 2 == 0) : 1'b1;
      if (i == chg_at) cmp_b = W'(chg_val);
      ta  = (tag_ovr.len() != 0) ? tag_ovr : pin_tag(oa, aa, t);
      tb_ = (tag_ovr.len() != 0) ? tag_ovr : pin_tag(ob, ab, t);
      @(posedge clk);
      fa = 1'b0; fb = 1'b0;
      if (dual && cnt_en) begin
        p = k % (2 * t);
        v = (p <= t) ? p : 2 * t - p;   // R2 ramp position
        down = (p >= t);
        fa = (v == aa); fb = (v == ab);
        pa = pin_next(pa, oa, 1'b1, topa, v, down, aa, t);
        pb = pin_next(pb, ob, 1'b0, topa, v, down, ab, t);
        if ((pc && p == t) || (!pc && p == 0)) begin   // R10 reload point
          aa = int'(cmp_a); ab = int'(cmp_b);
        end
        k++;
      end
      @(negedge clk);   // R12: registered outputs sampled one cycle after the step
      chk(ta,  "pwm_a", pwm_a, pa);
      chk(tb_, "pwm_b", pwm_b, pb);
      chk("R11 R12", "hit_a", hit_a, fa);
      chk("R11 R12", "hit_b", hit_b, fb);
      chk(toa, "pwm_a_oe", pwm_a_oe, ea);
      chk(tob, "pwm_b_oe", pwm_b_oe, eb);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst = 1'b1; wave_mode = 4'd10; om_a = 2'b11; om_b = 2'b11; cnt_en = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1", "pwm_a", pwm_a, 1'b0);
    chk("R1", "pwm_b", pwm_b, 1'b0);
    chk("R1", "pwm_a_oe", pwm_a_oe, 1'b0);
    chk("R1", "pwm_b_oe", pwm_b_oe, 1'b0);
    chk("R1", "hit_a", hit_a, 1'b0);
    chk("R1", "hit_b", hit_b, 1'b0);

    // R7, R8, R9: limit from top_val, both reload points, compare 0..TOP+1
    for (int m = 0; m < 2; m++)
      for (int pr = 0; pr < 2; pr++)
        for (int c = 0; c <= 7; c++)
          run_cfg(m == 0 ? 4'd10 : 4'd8, pr == 0 ? 2'b10 : 2'b11,
                  pr == 0 ? 2'b11 : 2'b10, c, 6 - c + (c == 7 ? 7 : 0), 6, 30,
                  1'b0, -1, 0, "");

    // R6: channel A toggles with limit from channel A; B sweeps 0..TOP+1
    for (int m = 0; m < 2; m++)
      for (int pr = 0; pr < 2; pr++)
        for (int c = 0; c <= 6; c++)
          run_cfg(m == 0 ? 4'd11 : 4'd9, 2'b01, pr == 0 ? 2'b10 : 2'b11,
                  5, c, 3, 26, 1'b0, -1, 0, "");

    // R3: limit follows channel A, not top_val
    run_cfg(4'd9, 2'b01, 2'b10, 4, 2, 9, 24, 1'b0, -1, 0, "R3");
    run_cfg(4'd10, 2'b10, 2'b10, 4, 2, 9, 24, 1'b0, -1, 0, "R3");

    // R6: toggle mode without limit from A leaves both pins undriven
    run_cfg(4'd8, 2'b01, 2'b01, 3, 3, 6, 20, 1'b0, -1, 0, "");
    // R5: mode 00, flags still pulse
    run_cfg(4'd10, 2'b00, 2'b00, 2, 0, 6, 20, 1'b0, -1, 0, "");
    // R4: non dual-slope modes
    run_cfg(4'd0, 2'b10, 2'b11, 0, 0, 6, 12, 1'b0, -1, 0, "R4");
    run_cfg(4'd3, 2'b11, 2'b10, 0, 2, 6, 12, 1'b0, -1, 0, "R4");
    // R2: gated steps
    run_cfg(4'd10, 2'b10, 2'b11, 2, 4, 5, 40, 1'b1, -1, 0, "R2");
    // R10: compare change mid-ramp, both reload points
    run_cfg(4'd10, 2'b10, 2'b10, 1, 2, 8, 40, 1'b0, 4, 5, "R10");
    run_cfg(4'd8, 2'b11, 2'b10, 1, 2, 8, 40, 1'b0, 4, 5, "R10");
    run_cfg(4'd10, 2'b10, 2'b11, 1, 2, 8, 40, 1'b0, 11, 6, "R10");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule